// File: doc/BRIEF.md
# Restoring Shift-Subtract Divider

This block divides one unsigned N-bit integer by another over a fixed run of clock cycles, with N set by a parameter (32 by default). A single-cycle start pulse captures both operands. The block then works one trial subtraction per clock until it has the quotient and the remainder. The working remainder is a double-width register that starts out holding the dividend. The divisor sits in the upper half of a second double-width register and moves one place right on every step. A trial difference that goes below zero is undone, and the matching quotient bit is 0. Otherwise the difference is kept and the quotient bit is 1.

Each run takes N+1 steps. On the clock edge that finishes the last step, the results go to registered outputs and a one-cycle completion pulse is raised. A zero divisor does not trap or stall. The run takes the same number of cycles and raises a flag beside the results.

Top module: `rdiv_top`

## Requirements
- R1: While reset is high, and after it is released with no start given, done, quotient, remainder and the zero-divisor flag are all 0.
- R2: For a nonzero divisor, the quotient output equals the unsigned integer quotient of dividend over divisor, rounded toward zero.
- R3: For a nonzero divisor, the remainder output equals dividend minus quotient times divisor, and is less than the divisor.
- R4: Done is high for exactly one cycle. Call the rising edge that samples start high while the block is idle edge 0. Done is then high in the cycle after edge N+1, which is 33 edges for the default N of 32.
- R5: Quotient, remainder and flag change only on the edge that raises done. They hold their values in every other cycle, including while a later run is in progress.
- R6: A start pulse that arrives while a run is in progress is ignored. The current run keeps its operands and its timing.
- R7: A divisor of 0 sets the zero-divisor flag to 1, returns all ones as the quotient and the dividend as the remainder, and keeps the latency of R4.
- R8: The zero-divisor flag returns to 0 when a later run with a nonzero divisor completes.
- R9: Operands whose top bit is 1 are treated as large unsigned values and never as negative ones, for both dividend and divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| i_start | input | 1 | Begin a division; sampled only when idle |
| i_dividend | input | N | Unsigned dividend, captured with start |
| i_divisor | input | N | Unsigned divisor, captured with start |
| o_done | output | 1 | One-cycle pulse when results are written |
| o_quotient | output | N | Registered quotient |
| o_remainder | output | N | Registered remainder |
| o_div_by_zero | output | 1 | Set when the completed run had a zero divisor |

## Verification
Two things can meet in one cycle: a new start request and a run that is still stepping. The bench provokes this by raising start with different operands partway through a run. It then judges the outcome three ways: the result must match the first operand pair, done must arrive at the cycle counted from the original start, and no second completion may follow. The bench also checks that the outputs of the finished run hold through the whole of a later run until the completion edge of that run replaces them.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rdiv_state_e;
endpackage

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
  import rdiv_pkg::*;
#(
  parameter int N = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic i_start,
  output logic o_load,
  output logic o_step,
  output logic o_last
);
  localparam int STEPS = N + 1;
  localparam int CW    = $clog2(STEPS + 1);

  rdiv_state_e    state_q;
  logic [CW-1:0]  cnt_q;

  assign o_load = (state_q == ST_IDLE) && i_start;
  assign o_step = (state_q == ST_RUN);
  assign o_last = o_step && (cnt_q == CW'(STEPS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (o_load) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else if (o_step) begin
      if (o_last) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R4: the step counter never runs past the final iteration
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN) |-> (cnt_q <= CW'(STEPS - 1)));

  // R6: a run that is not on its last step stays running whatever start does
  p_run_continues_r6: assert property (@(posedge clk) disable iff (rst)
    (o_step && !o_last) |=> (state_q == ST_RUN));

  // R4: the last step always returns the controller to idle
  p_last_to_idle_r4: assert property (@(posedge clk) disable iff (rst)
    o_last |=> (state_q == ST_IDLE));
endmodule

// File: rtl/rdiv_step.sv
module rdiv_step #(
  parameter int N = 32
) (
  input  logic [2*N-1:0] i_rem,
  input  logic [2*N-1:0] i_div,
  output logic [2*N-1:0] o_rem,
  output logic           o_qbit
);
  localparam int W = 2 * N;

  logic [W:0] trial;

  always_comb begin
    trial  = {1'b0, i_rem} - {1'b0, i_div};
    o_qbit = ~trial[W];
    o_rem  = o_qbit ? trial[W-1:0] : i_rem;
  end
endmodule

// File: rtl/rdiv_top.sv
module rdiv_top
  import rdiv_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         i_start,
  input  logic [N-1:0] i_dividend,
  input  logic [N-1:0] i_divisor,
  output logic         o_done,
  output logic [N-1:0] o_quotient,
  output logic [N-1:0] o_remainder,
  output logic         o_div_by_zero
);
  localparam int W = 2 * N;

  logic          load, step, last;
  logic [W-1:0]  rem_q, div_q, rem_nx;
  logic [N-1:0]  quo_q, quo_nx;
  logic          qbit, dbz_q;

  rdiv_ctrl #(.N(N)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .i_start(i_start),
    .o_load (load),
    .o_step (step),
    .o_last (last)
  );

  rdiv_step #(.N(N)) u_step (
    .i_rem (rem_q),
    .i_div (div_q),
    .o_rem (rem_nx),
    .o_qbit(qbit)
  );

  assign quo_nx = {quo_q[N-2:0], qbit};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      div_q <= '0;
      quo_q <= '0;
      dbz_q <= 1'b0;
    end else if (load) begin
      rem_q <= {{N{1'b0}}, i_dividend};
      div_q <= {i_divisor, {N{1'b0}}};
      quo_q <= '0;
      dbz_q <= (i_divisor == '0);
    end else if (step) begin
      rem_q <= rem_nx;
      quo_q <= quo_nx;
      div_q <= div_q >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_done        <= 1'b0;
      o_quotient    <= '0;
      o_remainder   <= '0;
      o_div_by_zero <= 1'b0;
    end else begin
      o_done <= last;
      if (last) begin
        o_quotient    <= dbz_q ? {N{1'b1}} : quo_nx;
        o_remainder   <= rem_nx[N-1:0];
        o_div_by_zero <= dbz_q;
      end
    end
  end

  // R4: completion is a single-cycle pulse
  p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
    o_done |=> !o_done);

  // R5: results move only together with done
  p_out_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !last |=> ($stable(o_quotient) && $stable(o_remainder) && $stable(o_div_by_zero)));

  // R7: a zero-divisor completion reports an all-ones quotient
  p_dbz_quot_r7: assert property (@(posedge clk) disable iff (rst)
    (o_done && o_div_by_zero) |-> (&o_quotient));

  // R3: a failed trial leaves the working remainder untouched
  p_restore_r3: assert property (@(posedge clk) disable iff (rst)
    (step && !qbit) |=> (rem_q == $past(rem_q)));

  // R3: the working remainder never grows during a run
  p_rem_shrinks_r3: assert property (@(posedge clk) disable iff (rst)
    step |=> (rem_q <= $past(rem_q)));
endmodule

// File: tb/rdiv_top_bench.sv
module rdiv_top_bench;
  localparam int N  = 32;
  localparam int NV = 10;
  localparam int LAT = N + 1;

  localparam logic [N-1:0] VA [NV] = '{
    32'd7, 32'd100, 32'd0, 32'd5, 32'hFFFF_FFFF,
    32'hFFFF_FFFF, 32'h8000_0000, 32'hDEAD_BEEF, 32'h1234_5678, 32'd1};
  localparam logic [N-1:0] VB [NV] = '{
    32'd2, 32'd7, 32'd5, 32'd9, 32'd1,
    32'hFFFF_FFFF, 32'd3, 32'h0000_1234, 32'hFFFF_FFFE, 32'd1};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [N-1:0] dvd = '0;
  logic [N-1:0] dvs = '0;
  logic         done;
  logic [N-1:0] quo, rem;
  logic         dbz;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  rdiv_top #(.N(N)) u_rdiv_top (
    .clk          (clk),
    .rst          (rst),
    .i_start      (start),
    .i_dividend   (dvd),
    .i_divisor    (dvs),
    .o_done       (done),
    .o_quotient   (quo),
    .o_remainder  (rem),
    .o_div_by_zero(dbz)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Runs one division; if intrude is set, a foreign start is raised mid-run.
  task automatic run(input logic [N-1:0] a, input logic [N-1:0] b,
                     input bit intrude, output int lat);
    @(negedge clk);
    dvd = a; dvs = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
      if (intrude && lat == 5) begin
        start = 1'b1; dvd = ~a; dvs = 32'd1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int lat;
    logic [N-1:0] hq, hr;
    repeat (3) @(negedge clk);
    chk("R1 done in reset", {31'd0, done}, '0);
    chk("R1 quotient in reset", quo, '0);
    chk("R1 remainder in reset", rem, '0);
    @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 done idle", {31'd0, done}, '0);
    chk("R1 flag idle", {31'd0, dbz}, '0);
    chk("R1 quotient idle", quo, '0);

    // Table walk: R2, R3, R9 (rows with top bit set), R4 latency and pulse
    for (int i = 0; i < NV; i++) begin
      run(VA[i], VB[i], 1'b0, lat);
      chk("R2 quotient", quo, VA[i] / VB[i]);
      chk("R3 remainder", rem, VA[i] % VB[i]);
      chk("R4 latency", lat, LAT);
      if (VA[i][N-1] || VB[i][N-1]) chk("R9 large operand quotient", quo, VA[i] / VB[i]);
      @(negedge clk);
      chk("R4 done single cycle", {31'd0, done}, '0);
    end

    // R5: hold after completion
    hq = quo; hr = rem;
    repeat (4) @(negedge clk);
    chk("R5 quotient hold", quo, hq);
    chk("R5 remainder hold", rem, hr);

    // R6 and R5: a second start mid-run is ignored; old results hold during the run
    @(negedge clk);
    dvd = 32'd1000; dvs = 32'd33; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    chk("R5 hold during run", quo, hq);
    start = 1'b1; dvd = 32'd5; dvs = 32'd1;
    @(negedge clk); start = 1'b0;
    lat = 11;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
    chk("R6 latency unchanged", lat, LAT);
    chk("R6 quotient of first operands", quo, 32'd30);
    chk("R6 remainder of first operands", rem, 32'd10);
    repeat (LAT + 3) begin
      @(negedge clk);
      if (done) chk("R6 no second completion", {31'd0, done}, '0);
    end

    // R6 via intrusion helper
    run(32'd77, 32'd8, 1'b1, lat);
    chk("R6 intruded quotient", quo, 32'd9);
    chk("R6 intruded remainder", rem, 32'd5);

    // R7: zero divisor
    run(32'hCAFE_0123, 32'd0, 1'b0, lat);
    chk("R7 flag", {31'd0, dbz}, 32'd1);
    chk("R7 quotient all ones", quo, 32'hFFFF_FFFF);
    chk("R7 remainder is dividend", rem, 32'hCAFE_0123);
    chk("R7 latency", lat, LAT);

    // R8: flag clears on next nonzero divisor
    run(32'd9, 32'd4, 1'b0, lat);
    chk("R8 flag cleared", {31'd0, dbz}, '0);
    chk("R8 quotient", quo, 32'd2);

    // R1: reset mid-run returns to the cleared state
    @(negedge clk); dvd = 32'd50; dvs = 32'd3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    repeat (LAT + 3) begin
      @(negedge clk);
      if (done) chk("R1 no completion after reset", {31'd0, done}, '0);
    end
    chk("R1 quotient after reset", quo, '0);

    summary();
  end
endmodule